// File: doc/BRIEF.md
# Sector Write Buffer and Programming Engine

This block is the write path of a byte-wide nonvolatile memory that is rewritten one whole sector at a time. A write request deposits one byte into a sector-sized staging buffer. Loads may target the sector's bytes in any order, and the sector is fixed by the first load of a load window. The window stays open as long as each accepted load follows the previous one within a programmable number of timer ticks. When that gap runs out, the block starts a timed program period. The period first erases the whole sector in a behavioural array and then writes the staged bytes into it.

While the program period runs, reads do not return array contents. They return a status byte. Its top bit is the inverse of the top bit of the last byte loaded, and its next bit flips on each read. Software polls either bit to find the end of programming. A `busy` output shows the same condition directly. All timers advance only on cycles where `tick_en` is high, so a clock divider outside the block sets the real time scale.

Top module: `sect_prog_engine`

## Requirements
- R1: After reset `busy`, `sect_err` and `rdata` are 0, and every array byte reads 8'hFF.
- R2: A load uses `addr[6:0]` as the byte offset in the sector and `addr[ADDR_W-1:7]` as the sector number. Offsets may be loaded in any order.
- R3: The load window stays open while accepted loads are spaced by fewer than `LOAD_TICKS` ticks. `busy` rises on the edge that carries the `LOAD_TICKS`-th tick after the last accepted load.
- R4: During a window, a load whose sector differs from the window's sector is dropped. It pulses `sect_err` high for one cycle and does not restart the window timer.
- R5: The program period lasts `ERASE_TICKS + PROG_TICKS` ticks with `busy` high throughout. Afterwards the sector holds the loaded bytes, its unloaded bytes read 8'hFF, and other sectors are unchanged.
- R6: `rdata` updates on the edge where `rd_en` is sampled high and holds its value otherwise.
- R7: A read while busy returns bit 7 equal to the inverse of bit 7 of the last loaded byte, and bits 5:0 equal to that byte's bits 5:0, whatever the address.
- R8: Bit 6 of busy reads is 0 on the first read of a program period and inverts on every further busy read.
- R9: Loads while `busy` is high are dropped without raising `sect_err`, and they open no new window.
- R10: No timer advances in a cycle with `tick_en` low, so `busy` neither rises nor falls without ticks.
- R11: Reprogramming a sector erases it first, so bytes loaded only in an earlier window read 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer advance enable |
| wr_en | input | 1 | Byte load request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte address, sector above offset |
| wdata | input | DATA_W | Load data |
| rdata | output | DATA_W | Registered read data or status |
| busy | output | 1 | Program period in progress |
| sect_err | output | 1 | One-cycle pulse on a dropped cross-sector load |

## Verification
The main function is tried with loads in scattered order, with a load that arrives just before the gap expires, with a load from another sector inside a window, and with loads that arrive while busy. Scattered order separates true offset decoding from a sequential pointer. The late load shows that the timer restarts, and the cross-sector load shows that a dropped load leaves the timer running. A second program of an already written sector separates a real erase from a merge. A run with ticks held low shows that every phase is gated by the enable.

// File: rtl/sect_pkg.sv
// Shared types for the sector programming engine.
// Assumes: nothing beyond the phase ordering used by the top.
package sect_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_ERASE = 2'd2,
        PH_PROG  = 2'd3
    } sect_phase_e;
endpackage

// File: rtl/sect_tick_timer.sv
// Tick counter shared by all phases: counts enabled ticks and flags the
// tick that reaches the given limit, then wraps to zero.
// Assumes: limit >= 1; clr has priority over counting.
module sect_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Terminal tick of the current phase.
    always_comb done = tick && (cnt_q == limit - CNT_W'(1)) && !clr;

    // Counter update: clear, wrap on done, else advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (done) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sect_load_buffer.sv
// Staging buffer for one sector: one byte register and one valid flag per
// offset, plus the window's sector number and the last loaded byte.
// Assumes: the caller only asserts we for accepted loads; first marks the
// load that opens a window and clears all other valid flags.
module sect_load_buffer #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 7,
    parameter int SECT_W = 3,
    localparam int BYTES = 1 << OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic                         first,
    input  logic [SECT_W-1:0]            sect_in,
    input  logic [OFF_W-1:0]             off_in,
    input  logic [DATA_W-1:0]            data_in,
    output logic [BYTES-1:0][DATA_W-1:0] buf_q,
    output logic [BYTES-1:0]             vld_q,
    output logic [SECT_W-1:0]            sect_q,
    output logic [DATA_W-1:0]            last_q
);
    genvar gi;
    generate
        for (gi = 0; gi < BYTES; gi++) begin : g_byte
            logic hit;
            always_comb hit = we && (off_in == OFF_W'(gi));

            // Byte cell: capture data on a load to this offset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    buf_q[gi] <= '0;
                end else if (hit) begin
                    buf_q[gi] <= data_in;
                end
            end

            // Valid flag: set on a hit, cleared when a new window opens.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[gi] <= 1'b0;
                end else if (hit) begin
                    vld_q[gi] <= 1'b1;
                end else if (we && first) begin
                    vld_q[gi] <= 1'b0;
                end
            end
        end
    endgenerate

    // Window sector and last loaded byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sect_q <= '0;
            last_q <= '0;
        end else if (we) begin
            if (first) sect_q <= sect_in;
            last_q <= data_in;
        end
    end
endmodule

// File: rtl/sect_array.sv
// Behavioural cell array: erases a whole sector to ERASED in one cycle and
// later writes the valid staged bytes of that sector; combinational read.
// Assumes: erase_stb and prog_stb never coincide.
module sect_array #(
    parameter int          DATA_W = 8,
    parameter int          OFF_W  = 7,
    parameter int          SECT_W = 3,
    parameter logic [7:0]  ERASED = 8'hFF,
    localparam int BYTES  = 1 << OFF_W,
    localparam int ADDR_W = SECT_W + OFF_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         erase_stb,
    input  logic                         prog_stb,
    input  logic [SECT_W-1:0]            tgt_sect,
    input  logic [BYTES-1:0][DATA_W-1:0] buf_in,
    input  logic [BYTES-1:0]             vld_in,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Array update: reset to erased, sector erase, then sector program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(ERASED);
        end else if (erase_stb) begin
            for (int i = 0; i < BYTES; i++)
                mem[{tgt_sect, OFF_W'(i)}] <= DATA_W'(ERASED);
        end else if (prog_stb) begin
            for (int i = 0; i < BYTES; i++)
                if (vld_in[i]) mem[{tgt_sect, OFF_W'(i)}] <= buf_in[i];
        end
    end

    // Read port.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/sect_prog_engine.sv
// Sector write buffer and programming engine. Accepts byte loads into a
// staging buffer, closes the load window after LOAD_TICKS idle ticks, then
// erases (ERASE_TICKS) and programs (PROG_TICKS) the sector. Reads while
// busy return polling status instead of array data.
// Assumes: DATA_W >= 3; wr_en and rd_en are not raised together.
module sect_prog_engine #(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int OFF_W       = 7,
    parameter int LOAD_TICKS  = 8,
    parameter int ERASE_TICKS = 4,
    parameter int PROG_TICKS  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              sect_err
);
    import sect_pkg::*;

    localparam int SECT_W = ADDR_W - OFF_W;
    localparam int BYTES  = 1 << OFF_W;
    localparam int MAX_LE = (LOAD_TICKS > ERASE_TICKS) ? LOAD_TICKS : ERASE_TICKS;
    localparam int MAX_T  = (MAX_LE > PROG_TICKS) ? MAX_LE : PROG_TICKS;
    localparam int CNT_W  = $clog2(MAX_T + 1);

    sect_phase_e              ph_q, ph_d;
    logic [SECT_W-1:0]        sect_in, sect_q;
    logic [OFF_W-1:0]         off_in;
    logic                     ld_first, ld_same, ld_bad, ld_we;
    logic                     tmr_clr, tmr_done;
    logic [CNT_W-1:0]         tmr_limit;
    logic [BYTES-1:0][DATA_W-1:0] buf_q;
    logic [BYTES-1:0]         vld_q;
    logic [DATA_W-1:0]        last_q, arr_rd, status;
    logic                     erase_stb, prog_stb;
    logic                     tog_q, err_q;
    logic [DATA_W-1:0]        rdata_q;

    // Address split and load classification.
    always_comb begin
        sect_in  = addr[ADDR_W-1:OFF_W];
        off_in   = addr[OFF_W-1:0];
        ld_first = wr_en && (ph_q == PH_IDLE);
        ld_same  = wr_en && (ph_q == PH_LOAD) && (sect_in == sect_q);
        ld_bad   = wr_en && (ph_q == PH_LOAD) && (sect_in != sect_q);
        ld_we    = ld_first || ld_same;
        busy     = (ph_q == PH_ERASE) || (ph_q == PH_PROG);
    end

    // Phase limit selection and timer restart.
    always_comb begin
        case (ph_q)
            PH_ERASE: tmr_limit = CNT_W'(ERASE_TICKS);
            PH_PROG:  tmr_limit = CNT_W'(PROG_TICKS);
            default:  tmr_limit = CNT_W'(LOAD_TICKS);
        endcase
        tmr_clr = ld_we || (ph_q == PH_IDLE);
    end

    sect_tick_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tick_en),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    // Phase sequencing.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE:  if (ld_first) ph_d = PH_LOAD;
            PH_LOAD:  if (tmr_done) ph_d = PH_ERASE;
            PH_ERASE: if (tmr_done) ph_d = PH_PROG;
            PH_PROG:  if (tmr_done) ph_d = PH_IDLE;
            default:  ph_d = PH_IDLE;
        endcase
        erase_stb = (ph_q == PH_ERASE) && tmr_done;
        prog_stb  = (ph_q == PH_PROG) && tmr_done;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    sect_load_buffer #(
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W),
        .SECT_W (SECT_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ld_we),
        .first   (ld_first),
        .sect_in (sect_in),
        .off_in  (off_in),
        .data_in (wdata),
        .buf_q   (buf_q),
        .vld_q   (vld_q),
        .sect_q  (sect_q),
        .last_q  (last_q)
    );

    sect_array #(
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W),
        .SECT_W (SECT_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_stb (erase_stb),
        .prog_stb  (prog_stb),
        .tgt_sect  (sect_q),
        .buf_in    (buf_q),
        .vld_in    (vld_q),
        .rd_addr   (addr),
        .rd_data   (arr_rd)
    );

    // Polling status byte: inverted top bit, toggle bit, low bits as loaded.
    always_comb status = {~last_q[DATA_W-1], tog_q, last_q[DATA_W-3:0]};

    // Toggle bit: cleared entering a program period, flips per busy read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (ph_q == PH_LOAD && ph_d == PH_ERASE) begin
            tog_q <= 1'b0;
        end else if (rd_en && busy) begin
            tog_q <= ~tog_q;
        end
    end

    // Read data register and cross-sector error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (rd_en) rdata_q <= busy ? status : arr_rd;
            err_q <= ld_bad;
        end
    end

    always_comb begin
        rdata    = rdata_q;
        sect_err = err_q;
    end
endmodule

// File: rtl/sect_prog_engine_chk.sv
// Port-level checker for the sector programming engine, bound to the top.
// Assumes: connected to the top's own ports only.
module sect_prog_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              busy,
    input logic              sect_err
);
    logic rdq, seen, prev6;

    // Track busy read results to compare consecutive toggle bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdq   <= 1'b0;
            seen  <= 1'b0;
            prev6 <= 1'b0;
        end else begin
            rdq <= rd_en && busy;
            if (rdq) begin
                seen  <= 1'b1;
                prev6 <= rdata[DATA_W-2];
            end else if (!busy) begin
                seen <= 1'b0;
            end
        end
    end

    // R8: consecutive busy reads of one period differ in bit 6.
    always_ff @(posedge clk) begin
        if (rst_n && rdq && seen) begin
            p_toggle_flips_r8: assert (rdata[DATA_W-2] != prev6)
                else $error("toggle bit did not flip");
        end
    end

    // R4: an error pulse always follows a load request.
    p_err_needs_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sect_err |-> $past(wr_en));

    // R9: a load while busy never raises the error flag.
    p_busy_ignores_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> !sect_err);

    // R10: without a tick the program period cannot end.
    p_busy_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_en) |=> busy);

    // R6: read data holds when no read is requested.
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind sect_prog_engine sect_prog_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .busy     (busy),
    .sect_err (sect_err)
);

// File: tb/tb_sect_prog_engine.sv
// Directed bench for the sector programming engine.
module tb_sect_prog_engine;
    localparam int AW = 10;
    localparam int LT = 8;
    localparam int ET = 4;
    localparam int PT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          busy, sect_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sect_prog_engine dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .busy(busy), .sect_err(sect_err)
    );

    function automatic logic [AW-1:0] ad(input int s, input int o);
        return AW'((s << 7) | o);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Load one byte on the next edge; returns at the following negedge.
    task automatic do_load(input int s, input int o, input logic [7:0] d);
        wr_en = 1'b1; addr = ad(s, o); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int s, input int o, output logic [7:0] q);
        rd_en = 1'b1; addr = ad(s, o);
        @(negedge clk);
        rd_en = 1'b0;
        q = rdata;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 1000) begin @(negedge clk); g++; end
    endtask

    // Checks busy stays low for LT-1 negedges and is high on the LT-th.
    task automatic chk_close(input string req);
        wait_n(LT - 1);
        chk(req, {7'd0, busy}, 8'd0);
        wait_n(1);
        chk(req, {7'd0, busy}, 8'd1);
    endtask

    task automatic t_reset();
        logic [7:0] q;
        chk("R1 busy", {7'd0, busy}, 8'd0);
        chk("R1 err", {7'd0, sect_err}, 8'd0);
        chk("R1 rdata", rdata, 8'h00);
        do_read(0, 0, q);  chk("R1 array", q, 8'hFF);
        do_read(7, 127, q); chk("R1 array", q, 8'hFF);
    endtask

    task automatic t_any_order();
        logic [7:0] q;
        do_load(1, 127, 8'hA5);
        do_load(1, 0, 8'h3C);
        do_load(1, 64, 8'h9C);
        chk_close("R3 close");
        do_read(3, 3, q); chk("R7 R8 first poll", q, 8'h1C);
        do_read(1, 64, q); chk("R8 second poll", q, 8'h5C);
        do_read(0, 9, q); chk("R8 third poll", q, 8'h1C);
        wait_idle();
        do_read(1, 127, q); chk("R2 off127", q, 8'hA5);
        do_read(1, 0, q);   chk("R2 off0", q, 8'h3C);
        do_read(1, 64, q);  chk("R2 off64", q, 8'h9C);
        wait_n(3);
        chk("R6 hold", rdata, 8'h9C);
        do_read(1, 1, q);   chk("R5 unloaded", q, 8'hFF);
        do_read(0, 64, q);  chk("R5 other sector", q, 8'hFF);
    endtask

    task automatic t_window_extend();
        logic [7:0] q;
        int n = 0;
        do_load(4, 3, 8'h10);
        wait_n(LT - 2);
        chk("R3 open late", {7'd0, busy}, 8'd0);
        do_load(4, 4, 8'h20);
        chk_close("R3 restart");
        while (busy && n < 100) begin n++; @(negedge clk); end
        chk("R5 duration", 8'(n), 8'(ET + PT));
        do_read(4, 3, q); chk("R5 byte a", q, 8'h10);
        do_read(4, 4, q); chk("R5 byte b", q, 8'h20);
    endtask

    task automatic t_bad_sector();
        logic [7:0] q;
        do_load(2, 5, 8'h11);
        do_load(3, 5, 8'h22);
        chk("R4 err pulse", {7'd0, sect_err}, 8'd1);
        wait_n(1);
        chk("R4 err one cycle", {7'd0, sect_err}, 8'd0);
        wait_n(LT - 3);
        chk("R4 timer kept", {7'd0, busy}, 8'd0);
        wait_n(1);
        chk("R4 timer kept", {7'd0, busy}, 8'd1);
        wait_idle();
        do_read(2, 5, q); chk("R4 good byte", q, 8'h11);
        do_read(3, 5, q); chk("R4 dropped byte", q, 8'hFF);
    endtask

    task automatic t_busy_load();
        logic [7:0] q;
        do_load(5, 0, 8'h77);
        wait_n(LT);
        chk("R9 busy", {7'd0, busy}, 8'd1);
        do_load(5, 0, 8'h88);
        chk("R9 no err", {7'd0, sect_err}, 8'd0);
        do_load(6, 0, 8'h99);
        chk("R9 no err", {7'd0, sect_err}, 8'd0);
        wait_idle();
        wait_n(LT + 4);
        chk("R9 no window", {7'd0, busy}, 8'd0);
        do_read(5, 0, q); chk("R9 kept", q, 8'h77);
        do_read(6, 0, q); chk("R9 dropped", q, 8'hFF);
    endtask

    task automatic t_reprogram();
        logic [7:0] q;
        do_load(2, 9, 8'h5A);
        chk_close("R3 close");
        wait_idle();
        do_read(2, 9, q); chk("R11 new", q, 8'h5A);
        do_read(2, 5, q); chk("R11 erased", q, 8'hFF);
    endtask

    task automatic t_tick_gate();
        logic [7:0] q;
        tick_en = 1'b0;
        do_load(7, 1, 8'h42);
        wait_n(20);
        chk("R10 load hold", {7'd0, busy}, 8'd0);
        tick_en = 1'b1;
        chk_close("R10 resume");
        tick_en = 1'b0;
        wait_n(30);
        chk("R10 busy hold", {7'd0, busy}, 8'd1);
        tick_en = 1'b1;
        wait_idle();
        do_read(7, 1, q); chk("R10 data", q, 8'h42);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_any_order();
        t_window_extend();
        t_bad_sector();
        t_busy_load();
        t_reprogram();
        t_tick_gate();
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule